// File: doc/BRIEF.md
# Interrupt Pin Request and Remote-IRR Tracker

This block holds the per-pin interrupt state of a 24-input interrupt router. Every cycle it takes the raw pin levels and the routing entry of each pin: polarity, trigger mode, mask, vector, delivery mode, destination mode and destination. From these it keeps a request bit for each pin and, for level-triggered pins, a remote-IRR flag. That flag blocks further deliveries until the interrupt has been acknowledged.

When a pin needs service, the block raises one delivery request. The request carries the pin's vector, trigger mode, delivery mode and destination. It holds that request until a reply arrives saying whether any target accepted it. End-of-interrupt messages arrive as a vector plus a level/edge flag. A level end-of-interrupt clears remote IRR on every pin programmed with that vector. It then sends the interrupt again if the line is still asserted. A separate decoder turns the destination into processors; that decoder and the register file are outside this block.

Top module: `irq_pin_tracker`

## Requirements
- R1: After reset, req_valid_o is 0 and every bit of irr_o and rirr_o is 0.
- R2: The effective level of a pin is pin_i XOR ent_pol_i. The pin's irr_o bit becomes 1 one clock edge after the effective level rises. It is 0 one edge after the effective level is low.
- R3: For an edge pin (ent_trig_i = 0), a rise of the effective level raises the request on the second clock edge after the rise is presented. That same edge clears the pin's irr_o bit, whatever the outcome of the delivery.
- R4: A level pin (ent_trig_i = 1) is delivered on a rise of its effective level only while its rirr_o bit is 0. A reply with rsp_ok_i = 1 sets rirr_o for that pin. A reply with rsp_ok_i = 0 (no target, including an empty destination set) leaves it 0.
- R5: A pin whose ent_mask_i bit is 1 produces no request when serviced. Its pending service is dropped.
- R6: Only one delivery is outstanding at a time. When several pins are pending, the lowest-numbered one is issued first.
- R7: While req_valid_o is 1 and no reply has come, req_pin_o, req_vec_o, req_trig_o, req_dmode_o, req_dlog_o and req_dest_o stay steady. These outputs carry the pin number and that pin's entry fields.
- R8: A request for pin 0 always carries req_dest_o = 0 and req_dlog_o = 0 (physical processor 0), whatever its entry says.
- R9: An end-of-interrupt with eoi_level_i = 1 clears rirr_o on every pin whose entry vector equals eoi_vec_i. One with eoi_level_i = 0, or with a vector no entry holds, changes no rirr_o bit.
- R10: If a level end-of-interrupt clears rirr_o on an unmasked pin whose irr_o bit is still 1, that pin is delivered again.
- R11: An end-of-interrupt presented while a delivery is outstanding waits in a queue of EOI_DEPTH entries. It takes effect only after the reply arrives.
- R12: A level pin whose effective level falls before it is issued is not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_PINS | Raw pin levels |
| ent_mask_i | input | N_PINS | Entry mask bit per pin |
| ent_pol_i | input | N_PINS | Entry polarity per pin (1 = active low) |
| ent_trig_i | input | N_PINS | Entry trigger mode per pin (1 = level) |
| ent_dlog_i | input | N_PINS | Entry destination mode per pin (1 = logical) |
| ent_vec_i | input | N_PINS*VEC_W | Entry vectors, pin p at bits [p*VEC_W +: VEC_W] |
| ent_dmode_i | input | N_PINS*3 | Entry delivery modes, pin p at bits [p*3 +: 3] |
| ent_dest_i | input | N_PINS*DEST_W | Entry destinations, pin p at bits [p*DEST_W +: DEST_W] |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | VEC_W | End-of-interrupt vector |
| eoi_level_i | input | 1 | End-of-interrupt is for a level-triggered interrupt |
| req_valid_o | output | 1 | Delivery request outstanding |
| req_pin_o | output | $clog2(N_PINS) | Pin being delivered |
| req_vec_o | output | VEC_W | Vector of the request |
| req_trig_o | output | 1 | Trigger mode of the request |
| req_dmode_o | output | 3 | Delivery mode of the request |
| req_dlog_o | output | 1 | Destination mode of the request |
| req_dest_o | output | DEST_W | Destination of the request |
| rsp_valid_i | input | 1 | Reply to the outstanding request |
| rsp_ok_i | input | 1 | Reply says at least one target accepted |
| irr_o | output | N_PINS | Request bit per pin |
| rirr_o | output | N_PINS | Remote-IRR flag per pin |

## Verification
Two things can land in the same cycle: the reply to an outstanding delivery and an end-of-interrupt aimed at another, still-asserted level pin. The bench provokes this in two ways. It presents one end-of-interrupt while the request waits, and another in the very cycle the reply is given. It then requires that remote IRR on the first pin stays set until the reply. After the reply, the flag must clear and exactly one fresh request must follow for that pin. A second pairing is a pin edge arriving while another pin is being issued. This covers both a level pulse that vanishes before arbitration and two edges raised together, where the lower pin must come out first.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int DMODE_W = 3;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trk_state_e;
endpackage

// File: rtl/irq_pin_cell.sv
module irq_pin_cell #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             pol_i,
  input  logic             level_trig_i,
  input  logic             mask_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             eoi_fire_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  input  logic             eoi_level_i,
  input  logic             pick_i,
  input  logic             accept_i,
  output logic             irr_o,
  output logic             rirr_o,
  output logic             pend_o
);
  logic eff, rise, eoi_hit;
  logic prev_q, irr_q, rirr_q, pend_q;
  logic irr_d, rirr_d, pend_d;

  assign eff     = raw_i ^ pol_i;
  assign rise    = eff & ~prev_q;
  assign eoi_hit = eoi_fire_i && eoi_level_i && (vec_i == eoi_vec_i);

  always_comb begin
    irr_d = 1'b0;
    if (eff) irr_d = (irr_q & ~(pick_i & ~level_trig_i)) | rise;

    pend_d = pend_q & ~pick_i;
    if (rise && (!level_trig_i || !rirr_q)) pend_d = 1'b1;
    if (eoi_hit && !mask_i && irr_q && level_trig_i) pend_d = 1'b1;
    // a withdrawn level request is not delivered
    if (level_trig_i && !eff) pend_d = 1'b0;

    rirr_d = rirr_q;
    if (accept_i) rirr_d = 1'b1;
    if (eoi_hit)  rirr_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      irr_q  <= 1'b0;
      rirr_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= eff;
      irr_q  <= irr_d;
      rirr_q <= rirr_d;
      pend_q <= pend_d;
    end
  end

  assign irr_o  = irr_q;
  assign rirr_o = rirr_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N = 24,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_eoi_fifo.sv
module irq_eoi_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic             full, do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  // full queue drops new messages unless a slot frees this cycle
  assign do_push = push_i && (!full || do_pop);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
  import irq_trk_pkg::*;
#(
  parameter int N_PINS    = 24,
  parameter int VEC_W     = 8,
  parameter int DEST_W    = 8,
  parameter int EOI_DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_PINS-1:0]            pin_i,
  input  logic [N_PINS-1:0]            ent_mask_i,
  input  logic [N_PINS-1:0]            ent_pol_i,
  input  logic [N_PINS-1:0]            ent_trig_i,
  input  logic [N_PINS-1:0]            ent_dlog_i,
  input  logic [N_PINS*VEC_W-1:0]      ent_vec_i,
  input  logic [N_PINS*DMODE_W-1:0]    ent_dmode_i,
  input  logic [N_PINS*DEST_W-1:0]     ent_dest_i,
  input  logic                         eoi_valid_i,
  input  logic [VEC_W-1:0]             eoi_vec_i,
  input  logic                         eoi_level_i,
  output logic                         req_valid_o,
  output logic [$clog2(N_PINS)-1:0]    req_pin_o,
  output logic [VEC_W-1:0]             req_vec_o,
  output logic                         req_trig_o,
  output logic [DMODE_W-1:0]           req_dmode_o,
  output logic                         req_dlog_o,
  output logic [DEST_W-1:0]            req_dest_o,
  input  logic                         rsp_valid_i,
  input  logic                         rsp_ok_i,
  output logic [N_PINS-1:0]            irr_o,
  output logic [N_PINS-1:0]            rirr_o
);
  localparam int PIN_W = $clog2(N_PINS);
  localparam int EOI_W = VEC_W + 1;
  localparam logic [N_PINS-1:0] ONE = {{(N_PINS-1){1'b0}}, 1'b1};

  logic [VEC_W-1:0]   vec_a   [N_PINS];
  logic [DEST_W-1:0]  dest_a  [N_PINS];
  logic [DMODE_W-1:0] dmode_a [N_PINS];

  logic [N_PINS-1:0] pend, pick_vec, accept_vec;
  logic              any_pend, pick_en, eoi_fire, q_empty, done;
  logic [PIN_W-1:0]  pick_idx;
  logic [EOI_W-1:0]  q_head;

  trk_state_e         state_q;
  logic [PIN_W-1:0]   lat_pin_q;
  logic [VEC_W-1:0]   lat_vec_q;
  logic               lat_trig_q, lat_dlog_q;
  logic [DMODE_W-1:0] lat_dmode_q;
  logic [DEST_W-1:0]  lat_dest_q;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    assign vec_a[g]   = ent_vec_i[g*VEC_W +: VEC_W];
    assign dest_a[g]  = ent_dest_i[g*DEST_W +: DEST_W];
    assign dmode_a[g] = ent_dmode_i[g*DMODE_W +: DMODE_W];

    irq_pin_cell #(.VEC_W(VEC_W)) u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .raw_i        (pin_i[g]),
      .pol_i        (ent_pol_i[g]),
      .level_trig_i (ent_trig_i[g]),
      .mask_i       (ent_mask_i[g]),
      .vec_i        (vec_a[g]),
      .eoi_fire_i   (eoi_fire),
      .eoi_vec_i    (q_head[VEC_W-1:0]),
      .eoi_level_i  (q_head[VEC_W]),
      .pick_i       (pick_vec[g]),
      .accept_i     (accept_vec[g]),
      .irr_o        (irr_o[g]),
      .rirr_o       (rirr_o[g]),
      .pend_o       (pend[g])
    );
  end

  irq_lowest_pick #(.N(N_PINS)) u_pick (
    .req_i   (pend),
    .valid_o (any_pend),
    .idx_o   (pick_idx)
  );

  irq_eoi_fifo #(.DEPTH(EOI_DEPTH), .WIDTH(EOI_W)) u_eoi_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (eoi_valid_i),
    .data_i  ({eoi_level_i, eoi_vec_i}),
    .pop_i   (eoi_fire),
    .data_o  (q_head),
    .empty_o (q_empty)
  );

  // queued end-of-interrupt work goes before new issues
  assign eoi_fire   = (state_q == TRK_IDLE) && !q_empty;
  assign pick_en    = (state_q == TRK_IDLE) && q_empty && any_pend;
  assign pick_vec   = pick_en ? (ONE << pick_idx) : '0;
  assign done       = (state_q == TRK_WAIT) && rsp_valid_i;
  assign accept_vec = (done && rsp_ok_i && lat_trig_q) ? (ONE << lat_pin_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= TRK_IDLE;
      lat_pin_q   <= '0;
      lat_vec_q   <= '0;
      lat_trig_q  <= 1'b0;
      lat_dmode_q <= '0;
      lat_dlog_q  <= 1'b0;
      lat_dest_q  <= '0;
    end else begin
      case (state_q)
        TRK_IDLE: begin
          if (pick_en && !ent_mask_i[pick_idx]) begin
            state_q     <= TRK_WAIT;
            lat_pin_q   <= pick_idx;
            lat_vec_q   <= vec_a[pick_idx];
            lat_trig_q  <= ent_trig_i[pick_idx];
            lat_dmode_q <= dmode_a[pick_idx];
            if (pick_idx == '0) begin
              lat_dlog_q <= 1'b0;
              lat_dest_q <= '0;
            end else begin
              lat_dlog_q <= ent_dlog_i[pick_idx];
              lat_dest_q <= dest_a[pick_idx];
            end
          end
        end
        TRK_WAIT: begin
          if (done) state_q <= TRK_IDLE;
        end
        default: state_q <= TRK_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == TRK_WAIT);
  assign req_pin_o   = lat_pin_q;
  assign req_vec_o   = lat_vec_q;
  assign req_trig_o  = lat_trig_q;
  assign req_dmode_o = lat_dmode_q;
  assign req_dlog_o  = lat_dlog_q;
  assign req_dest_o  = lat_dest_q;
endmodule

// File: rtl/irq_pin_tracker_chk.sv
module irq_pin_tracker_chk #(
  parameter int N_PINS = 24,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_PINS-1:0]         pin_i,
  input logic [N_PINS-1:0]         ent_pol_i,
  input logic                      req_valid_o,
  input logic [$clog2(N_PINS)-1:0] req_pin_o,
  input logic [VEC_W-1:0]          req_vec_o,
  input logic                      req_trig_o,
  input logic                      req_dlog_o,
  input logic [DEST_W-1:0]         req_dest_o,
  input logic                      rsp_valid_i,
  input logic                      rsp_ok_i,
  input logic [N_PINS-1:0]         irr_o,
  input logic [N_PINS-1:0]         rirr_o
);
  // R2
  irr_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irr_o & ~$past(pin_i ^ ent_pol_i)) == '0);

  // R4
  rirr_set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rirr_o & ~$past(rirr_o)) != '0) |->
      $past(req_valid_o && rsp_valid_i && rsp_ok_i && req_trig_o));

  // R6
  single_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rirr_o & ~$past(rirr_o)) <= 1);

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !rsp_valid_i) |=>
      (req_valid_o && $stable(req_pin_o) && $stable(req_vec_o) && $stable(req_dest_o)));

  // R8
  pin0_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_pin_o == '0) |-> (req_dest_o == '0 && !req_dlog_o));

  // R11
  eoi_deferred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(rirr_o) & ~rirr_o) != '0) |-> !$past(req_valid_o));
endmodule

bind irq_pin_tracker irq_pin_tracker_chk #(
  .N_PINS (N_PINS),
  .VEC_W  (VEC_W),
  .DEST_W (DEST_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pin_i       (pin_i),
  .ent_pol_i   (ent_pol_i),
  .req_valid_o (req_valid_o),
  .req_pin_o   (req_pin_o),
  .req_vec_o   (req_vec_o),
  .req_trig_o  (req_trig_o),
  .req_dlog_o  (req_dlog_o),
  .req_dest_o  (req_dest_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_ok_i    (rsp_ok_i),
  .irr_o       (irr_o),
  .rirr_o      (rirr_o)
);

// File: tb/irq_pin_tracker_bench.sv
module irq_pin_tracker_bench;
  localparam int N  = 24;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam int MW = 3;
  localparam int PW = $clog2(N);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] pin = '0, mask = '1, pol = '0, trig = '0, dlog = '0;
  logic [N*VW-1:0] evec = '0;
  logic [N*MW-1:0] edm = '0;
  logic [N*DW-1:0] edest = '0;
  logic eoi_v = 1'b0, eoi_l = 1'b0;
  logic [VW-1:0] eoi_vec = '0;
  logic rsp_v = 1'b0, rsp_ok = 1'b0;
  logic req_valid, req_trig, req_dlog;
  logic [PW-1:0] req_pin;
  logic [VW-1:0] req_vec;
  logic [MW-1:0] req_dmode;
  logic [DW-1:0] req_dest;
  logic [N-1:0] irr, rirr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_pin_tracker #(.N_PINS(N), .VEC_W(VW), .DEST_W(DW), .EOI_DEPTH(4)) u_irq_pin_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin), .ent_mask_i(mask), .ent_pol_i(pol),
    .ent_trig_i(trig), .ent_dlog_i(dlog), .ent_vec_i(evec), .ent_dmode_i(edm),
    .ent_dest_i(edest), .eoi_valid_i(eoi_v), .eoi_vec_i(eoi_vec), .eoi_level_i(eoi_l),
    .req_valid_o(req_valid), .req_pin_o(req_pin), .req_vec_o(req_vec),
    .req_trig_o(req_trig), .req_dmode_o(req_dmode), .req_dlog_o(req_dlog),
    .req_dest_o(req_dest), .rsp_valid_i(rsp_v), .rsp_ok_i(rsp_ok),
    .irr_o(irr), .rirr_o(rirr)
  );

  // row: {pin, vector, flags}; flags = trig,pol,mask,ok,exp_req,exp_rirr,exp_irr,0
  localparam logic [23:0] TBL [8] = '{
    {8'd3,  8'h31, 8'b0001_1000},
    {8'd5,  8'h42, 8'b1001_1110},
    {8'd7,  8'h50, 8'b1101_1110},
    {8'd9,  8'h61, 8'b1000_1010},
    {8'd11, 8'h72, 8'b0011_0000},
    {8'd13, 8'h83, 8'b1011_0010},
    {8'd0,  8'h94, 8'b1001_1110},
    {8'd23, 8'hA5, 8'b0100_1000}
  };

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_entry(input int p, input logic t, input logic pl, input logic m,
                           input logic [VW-1:0] v);
    trig[p] = t; pol[p] = pl; mask[p] = m; dlog[p] = 1'b1;
    evec[p*VW +: VW] = v;
    edm[p*MW +: MW] = MW'(p % 5);
    edest[p*DW +: DW] = 8'hA0 | DW'(p);
  endtask

  task automatic wait_req(input int max, output bit got);
    got = 1'b0;
    for (int i = 0; i < max; i++) begin
      if (!got) begin
        tick();
        if (req_valid) got = 1'b1;
      end
    end
  endtask

  task automatic respond(input logic ok);
    rsp_v = 1'b1; rsp_ok = ok;
    tick();
    rsp_v = 1'b0; rsp_ok = 1'b0;
  endtask

  task automatic send_eoi(input logic [VW-1:0] v, input logic lvl);
    eoi_v = 1'b1; eoi_vec = v; eoi_l = lvl;
    tick();
    eoi_v = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit got;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 req_valid after reset", 32'(req_valid), 0);
    chk("R1 irr after reset", 32'(irr), 0);
    chk("R1 rirr after reset", 32'(rirr), 0);

    // table of single-pin scenarios
    for (int r = 0; r < 8; r++) begin
      int p;
      logic [7:0] f;
      logic [VW-1:0] v;
      p = int'(TBL[r][23:16]);
      v = TBL[r][15:8];
      f = TBL[r][7:0];
      set_entry(p, f[7], f[6], f[5], v);
      pin[p] = f[6];
      tick(); tick();
      pin[p] = ~f[6];
      wait_req(6, got);
      chk($sformatf("R3/R4/R5 request row %0d", r), 32'(got), 32'(f[3]));
      if (got) begin
        chk($sformatf("R7 pin row %0d", r), 32'(req_pin), 32'(p));
        chk($sformatf("R7 vector row %0d", r), 32'(req_vec), 32'(v));
        chk($sformatf("R7 trig row %0d", r), 32'(req_trig), 32'(f[7]));
        chk($sformatf("R7 dmode row %0d", r), 32'(req_dmode), 32'(p % 5));
        if (p == 0) begin
          chk("R8 pin0 dest", 32'(req_dest), 0);
          chk("R8 pin0 dest mode", 32'(req_dlog), 0);
        end else begin
          chk($sformatf("R7 dest row %0d", r), 32'(req_dest), 32'(8'hA0 | p));
        end
        respond(f[4]);
      end
      tick();
      chk($sformatf("R4 rirr row %0d", r), 32'(rirr[p]), 32'(f[2]));
      chk($sformatf("R2 irr row %0d", r), 32'(irr[p]), 32'(f[1]));
      pin[p] = f[6];
      tick(); tick();
      if (rirr[p]) send_eoi(v, 1'b1);
      tick(); tick(); tick();
      chk($sformatf("R9 rirr cleared row %0d", r), 32'(rirr[p]), 0);
      chk($sformatf("R12 no request row %0d", r), 32'(req_valid), 0);
      mask[p] = 1'b1;
    end

    // exact latency, irr timing, request hold
    set_entry(2, 1'b0, 1'b0, 1'b0, 8'h21);
    tick();
    pin[2] = 1'b1;
    tick();
    chk("R3 no request after one edge", 32'(req_valid), 0);
    chk("R2 irr set after rise", 32'(irr[2]), 1);
    tick();
    chk("R3 request on second edge", 32'(req_valid), 1);
    chk("R3 edge irr cleared at issue", 32'(irr[2]), 0);
    repeat (4) tick();
    chk("R7 request held", 32'(req_valid), 1);
    chk("R7 vector held", 32'(req_vec), 32'h21);
    respond(1'b1);
    chk("R4 edge pin keeps rirr clear", 32'(rirr[2]), 0);
    pin[2] = 1'b0;
    tick();

    // priority of simultaneous edges
    set_entry(4, 1'b0, 1'b0, 1'b0, 8'h14);
    set_entry(1, 1'b0, 1'b0, 1'b0, 8'h11);
    tick();
    pin[4] = 1'b1; pin[1] = 1'b1;
    wait_req(6, got);
    chk("R6 lower pin first", 32'(req_pin), 1);
    respond(1'b1);
    wait_req(6, got);
    chk("R6 second pin follows", 32'({got, 3'b0, req_pin}), 32'({1'b1, 3'b0, 5'd4}));
    respond(1'b1);
    pin[4] = 1'b0; pin[1] = 1'b0;
    tick();

    // level pin, remote IRR gating and EOI forms
    set_entry(6, 1'b1, 1'b0, 1'b0, 8'h66);
    tick();
    pin[6] = 1'b1;
    wait_req(6, got);
    chk("R4 level pin delivered", 32'({got, 3'b0, req_pin}), 32'({1'b1, 3'b0, 5'd6}));
    respond(1'b1);
    chk("R4 rirr set on accept", 32'(rirr[6]), 1);
    pin[6] = 1'b0; tick(); tick();
    pin[6] = 1'b1;
    wait_req(6, got);
    chk("R4 blocked while rirr set", 32'(got), 0);
    send_eoi(8'h66, 1'b0);
    tick(); tick(); tick();
    chk("R9 edge EOI ignored", 32'(rirr[6]), 1);
    send_eoi(8'h67, 1'b1);
    tick(); tick(); tick();
    chk("R9 vector mismatch ignored", 32'({rirr[6], req_valid}), 32'(2'b10));
    send_eoi(8'h66, 1'b1);
    wait_req(6, got);
    chk("R10 redelivered after EOI", 32'({got, 3'b0, req_pin}), 32'({1'b1, 3'b0, 5'd6}));
    chk("R9 rirr cleared by EOI", 32'(rirr[6]), 0);
    respond(1'b1);
    chk("R4 rirr set again", 32'(rirr[6]), 1);
    pin[6] = 1'b0; tick();
    send_eoi(8'h66, 1'b1);
    tick(); tick(); tick();
    chk("R12 no redelivery with line low", 32'({rirr[6], req_valid}), 0);

    // one EOI vector shared by two pins
    set_entry(14, 1'b1, 1'b0, 1'b0, 8'h80);
    set_entry(15, 1'b1, 1'b0, 1'b0, 8'h80);
    tick();
    pin[14] = 1'b1; pin[15] = 1'b1;
    wait_req(6, got); respond(1'b1);
    wait_req(6, got); respond(1'b1);
    chk("R4 both pins remote IRR", 32'(rirr[15:14]), 32'(2'b11));
    pin[14] = 1'b0; pin[15] = 1'b0;
    tick();
    send_eoi(8'h80, 1'b1);
    tick(); tick(); tick();
    chk("R9 EOI clears all matching pins", 32'(rirr[15:14]), 0);

    // EOI during an outstanding delivery, and in the reply cycle
    set_entry(16, 1'b1, 1'b0, 1'b0, 8'h90);
    set_entry(17, 1'b0, 1'b0, 1'b0, 8'h91);
    tick();
    pin[16] = 1'b1;
    wait_req(6, got); respond(1'b1);
    chk("R4 pin 16 remote IRR", 32'(rirr[16]), 1);
    pin[17] = 1'b1;
    wait_req(6, got);
    chk("R6 pin 17 outstanding", 32'(req_pin), 17);
    send_eoi(8'h90, 1'b1);
    tick(); tick();
    chk("R11 EOI deferred while busy", 32'({rirr[16], req_valid}), 32'(2'b11));
    eoi_v = 1'b1; eoi_vec = 8'h90; eoi_l = 1'b1;
    respond(1'b1);
    eoi_v = 1'b0;
    wait_req(8, got);
    chk("R11 EOI applied after reply", 32'({got, 3'b0, req_pin}), 32'({1'b1, 3'b0, 5'd16}));
    chk("R11 rirr cleared after reply", 32'(rirr[16]), 0);
    respond(1'b1);
    wait_req(6, got);
    chk("R10 single redelivery", 32'({got, rirr[16]}), 32'(2'b01));
    pin[16] = 1'b0; pin[17] = 1'b0;
    tick();
    send_eoi(8'h90, 1'b1);
    tick(); tick(); tick();

    // level request withdrawn while another delivery waits
    set_entry(18, 1'b0, 1'b0, 1'b0, 8'hA8);
    set_entry(19, 1'b1, 1'b0, 1'b0, 8'hA9);
    tick();
    pin[18] = 1'b1;
    wait_req(6, got);
    pin[19] = 1'b1; tick(); tick();
    pin[19] = 1'b0;
    tick();
    respond(1'b1);
    wait_req(6, got);
    chk("R12 withdrawn level not delivered", 32'(got), 0);
    chk("R2 irr low after withdrawal", 32'(irr[19]), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule